// File: doc/BRIEF.md
# Timed Stream Command Queue

This block sits between a processor's write-only settings bus and a sample-capture controller. Software describes a receive streaming request with three 32-bit writes: a control word, a start-time seconds word and a start-time ticks word. The first two writes only stage their values. The ticks write commits all three as one entry into a small FIFO, so a half-written command never reaches the capture side.

On the output side the head entry is offered to the consumer over a valid/ready handshake. An entry whose immediate flag is clear is held back until the incoming time (seconds, ticks) reaches its start time. An entry with the immediate flag set is offered at once. The consumer takes an entry in any cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the offered entry stays in place and its fields do not change. A producer has no back-pressure path, because the settings bus cannot stall. A commit that arrives while the FIFO is full is therefore dropped and raises a sticky error flag.

The block also keeps a sticky overrun flag. A pulse from the capture side sets it, and a write to a dedicated clear register resets it.

Top module: `stream_cmd_queue`

## Requirements
- R1: Control word layout: bit 31 is the immediate flag (`cmd_now`), bit 30 is the chain flag (`cmd_chain`), and bits 29:0 are the sample count (`cmd_count`). Each field appears unchanged on the output.
- R2: The register index on `set_addr` is BASE+0 for the control word, BASE+1 for seconds, BASE+2 for ticks and BASE+3 for overrun clear. With the default BASE, these indices are 0x40 to 0x43.
- R3: Writes to the control word or the seconds word only stage the value, and no FIFO entry is created by them.
- R4: A ticks write pushes the staged control word, the staged seconds and the written ticks as one entry. If the FIFO was empty, `cmd_valid` rises on the cycle after the write.
- R5: Entries leave in the order their ticks writes arrived.
- R6: An entry leaves only on a cycle with `cmd_valid` and `cmd_ready` both high. While `cmd_ready` is low, the offered fields are held.
- R7: A head entry with the immediate flag clear is offered only when {time_secs, time_ticks} is greater than or equal to {cmd_secs, cmd_ticks}.
- R8: A head entry with the immediate flag set is offered regardless of the time inputs.
- R9: The FIFO holds DEPTH entries (default 8). A ticks write while it is full is dropped and leaves the queued entries unchanged. The same write sets the sticky `cmd_err` flag, which only reset clears.
- R10: A high cycle on `ovr_pulse` sets `overrun`, which stays set.
- R11: A write to BASE+3 with any data clears `overrun`. If `ovr_pulse` is high in the same cycle, `overrun` stays set.
- R12: After reset, `cmd_valid`, `overrun` and `cmd_err` are low and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | 8 | Register index (word address) |
| set_data | input | 32 | Write data |
| time_secs | input | 32 | Current time, seconds |
| time_ticks | input | 32 | Current time, ticks |
| ovr_pulse | input | 1 | Overrun event from the capture side |
| cmd_valid | output | 1 | Head entry offered |
| cmd_ready | input | 1 | Consumer accepts the head entry |
| cmd_now | output | 1 | Immediate flag of the head entry |
| cmd_chain | output | 1 | Chain flag of the head entry |
| cmd_count | output | 30 | Sample count of the head entry |
| cmd_secs | output | 32 | Start seconds of the head entry |
| cmd_ticks | output | 32 | Start ticks of the head entry |
| overrun | output | 1 | Sticky overrun flag |
| cmd_err | output | 1 | Sticky dropped-command flag |

## Verification
The hardest case to reach from the ports is a commit against a full FIFO. Reaching it takes eight complete three-word commits with the consumer held off, and then a ninth commit. Draining the queue afterwards must show exactly the first eight counts in order and nothing more. The boundary of timed release is also tested: the time inputs are stepped one tick below, exactly at, and beyond the command time, including a seconds carry, while the entry waits at the head.

// File: rtl/scq_pkg.sv
package scq_pkg;
  parameter int WORD_W  = 32;
  parameter int COUNT_W = WORD_W - 2;

  typedef struct packed {
    logic               now;
    logic               chain;
    logic [COUNT_W-1:0] count;
    logic [WORD_W-1:0]  secs;
    logic [WORD_W-1:0]  ticks;
  } scq_cmd_t;
endpackage

// File: rtl/scq_decode.sv
module scq_decode
  import scq_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  BASE   = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stb,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [WORD_W-1:0] set_data,
  output logic              push_req,
  output scq_cmd_t          push_entry,
  output logic              clr_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_SECS = ADDR_W'(BASE + 8'd1);
  localparam logic [ADDR_W-1:0] A_TCKS = ADDR_W'(BASE + 8'd2);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE + 8'd3);

  logic [WORD_W-1:0] ctrl_q, secs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      secs_q <= '0;
    end else if (set_stb) begin
      if (set_addr == A_CTRL) ctrl_q <= set_data;
      if (set_addr == A_SECS) secs_q <= set_data;
    end
  end

  assign push_req = set_stb && (set_addr == A_TCKS);
  assign clr_req  = set_stb && (set_addr == A_CLR);

  always_comb begin
    push_entry.now   = ctrl_q[WORD_W-1];
    push_entry.chain = ctrl_q[WORD_W-2];
    push_entry.count = ctrl_q[COUNT_W-1:0];
    push_entry.secs  = secs_q;
    push_entry.ticks = set_data;
  end

  // R3
  stage_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && (set_addr == A_CTRL || set_addr == A_SECS)) |-> !push_req);
endmodule

// File: rtl/scq_fifo.sv
module scq_fifo
  import scq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  scq_cmd_t push_entry,
  input  logic     pop,
  output scq_cmd_t head,
  output logic     empty,
  output logic     full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  scq_cmd_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R4
  push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty);
endmodule

// File: rtl/scq_gate.sv
module scq_gate
  import scq_pkg::*;
(
  input  scq_cmd_t          head,
  input  logic              empty,
  input  logic [WORD_W-1:0] time_secs,
  input  logic [WORD_W-1:0] time_ticks,
  output logic              offer
);
  logic reached;
  assign reached = {time_secs, time_ticks} >= {head.secs, head.ticks};
  assign offer   = !empty && (head.now || reached);
endmodule

// File: rtl/stream_cmd_queue.sv
module stream_cmd_queue
  import scq_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter logic [7:0] BASE   = 8'h40,
  parameter int         DEPTH  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_stb,
  input  logic [ADDR_W-1:0]  set_addr,
  input  logic [WORD_W-1:0]  set_data,
  input  logic [WORD_W-1:0]  time_secs,
  input  logic [WORD_W-1:0]  time_ticks,
  input  logic               ovr_pulse,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic               cmd_now,
  output logic               cmd_chain,
  output logic [COUNT_W-1:0] cmd_count,
  output logic [WORD_W-1:0]  cmd_secs,
  output logic [WORD_W-1:0]  cmd_ticks,
  output logic               overrun,
  output logic               cmd_err
);
  logic     push_req, clr_req, empty, full, pop;
  scq_cmd_t push_entry, head;

  scq_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .set_addr(set_addr),
    .set_data(set_data), .push_req(push_req), .push_entry(push_entry),
    .clr_req(clr_req)
  );

  scq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_req && !full),
    .push_entry(push_entry), .pop(pop), .head(head),
    .empty(empty), .full(full)
  );

  scq_gate u_gate (
    .head(head), .empty(empty), .time_secs(time_secs),
    .time_ticks(time_ticks), .offer(cmd_valid)
  );

  assign pop       = cmd_valid && cmd_ready;
  assign cmd_now   = head.now;
  assign cmd_chain = head.chain;
  assign cmd_count = head.count;
  assign cmd_secs  = head.secs;
  assign cmd_ticks = head.ticks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      if (ovr_pulse)    overrun <= 1'b1;
      else if (clr_req) overrun <= 1'b0;
      if (push_req && full) cmd_err <= 1'b1;
    end
  end

  // R10
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_pulse |=> overrun);
  // R11
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !ovr_pulse) |=> !overrun);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> ($stable(cmd_count) && $stable(cmd_secs) && $stable(cmd_ticks)));
endmodule

// File: tb/test_stream_cmd_queue.sv
module test_stream_cmd_queue;
  localparam logic [7:0] B = 8'h40;
  localparam int DEPTH = 8;

  logic        clk = 0, rst_n = 0, set_stb = 0, ovr_pulse = 0, cmd_ready = 0;
  logic [7:0]  set_addr = 0;
  logic [31:0] set_data = 0, time_secs = 0, time_ticks = 0;
  logic        cmd_valid, cmd_now, cmd_chain, overrun, cmd_err;
  logic [29:0] cmd_count;
  logic [31:0] cmd_secs, cmd_ticks;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  stream_cmd_queue i_stream_cmd_queue (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .set_addr(set_addr),
    .set_data(set_data), .time_secs(time_secs), .time_ticks(time_ticks),
    .ovr_pulse(ovr_pulse), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_now(cmd_now), .cmd_chain(cmd_chain), .cmd_count(cmd_count),
    .cmd_secs(cmd_secs), .cmd_ticks(cmd_ticks), .overrun(overrun),
    .cmd_err(cmd_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); set_stb = 1; set_addr = a; set_data = d;
    @(negedge clk); set_stb = 0;
  endtask

  task automatic send(input logic now, input logic chain, input logic [29:0] n,
                      input logic [31:0] s, input logic [31:0] t);
    wr(B, {now, chain, n}); wr(B + 8'd1, s); wr(B + 8'd2, t);
  endtask

  task automatic take;
    @(negedge clk); cmd_ready = 1;
    @(negedge clk); cmd_ready = 0;
  endtask

  task automatic t_reset;
    check("R12 valid", cmd_valid, 0);
    check("R12 overrun", overrun, 0);
    check("R12 err", cmd_err, 0);
  endtask

  task automatic t_stage;
    wr(B, {1'b1, 1'b1, 30'h2345_678});
    wr(B + 8'd1, 32'h0000_0011);
    check("R3 no entry", cmd_valid, 0);
    wr(B + 8'd2, 32'h0000_0022);
    check("R4 valid after ticks", cmd_valid, 1);
    check("R1 now", cmd_now, 1);
    check("R1 chain", cmd_chain, 1);
    check("R1 count", cmd_count, 30'h2345_678);
    check("R2 secs", cmd_secs, 32'h11);
    check("R2 ticks", cmd_ticks, 32'h22);
    take();
    check("R6 removed", cmd_valid, 0);
  endtask

  task automatic t_order;
    send(1, 0, 30'd101, 0, 0);
    send(1, 1, 30'd102, 0, 0);
    send(1, 0, 30'd103, 0, 0);
    repeat (3) @(negedge clk);
    check("R6 held valid", cmd_valid, 1);
    check("R6 held count", cmd_count, 30'd101);
    for (int i = 0; i < 3; i++) begin
      check("R5 order", cmd_count, 30'(101 + i));
      take();
    end
    check("R5 empty", cmd_valid, 0);
  endtask

  task automatic t_timed;
    time_secs = 5; time_ticks = 199;
    send(0, 0, 30'd7, 32'd5, 32'd200);
    check("R7 early", cmd_valid, 0);
    time_ticks = 200; #1;
    check("R7 equal", cmd_valid, 1);
    time_secs = 4; time_ticks = 999; #1;
    check("R7 earlier secs", cmd_valid, 0);
    time_secs = 6; time_ticks = 0; #1;
    check("R7 later secs", cmd_valid, 1);
    take();
    time_secs = 0; time_ticks = 0;
    send(1, 0, 30'd8, 32'd50, 32'd50);
    check("R8 now ignores time", cmd_valid, 1);
    take();
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH; i++) send(1, 0, 30'(200 + i), 0, 0);
    check("R9 no err yet", cmd_err, 0);
    send(1, 0, 30'd999, 0, 0);
    check("R9 err set", cmd_err, 1);
    for (int i = 0; i < DEPTH; i++) begin
      check("R9 kept entry", cmd_count, 30'(200 + i));
      take();
    end
    check("R9 dropped entry absent", cmd_valid, 0);
    check("R9 err sticky", cmd_err, 1);
  endtask

  task automatic t_overrun;
    @(negedge clk); ovr_pulse = 1;
    @(negedge clk); ovr_pulse = 0;
    repeat (3) @(negedge clk);
    check("R10 sticky", overrun, 1);
    wr(B + 8'd3, 32'hDEAD_BEEF);
    check("R11 cleared", overrun, 0);
    @(negedge clk); ovr_pulse = 1; set_stb = 1; set_addr = B + 8'd3; set_data = 0;
    @(negedge clk); ovr_pulse = 0; set_stb = 0;
    check("R11 set wins", overrun, 1);
    check("R3 clear write pushes nothing", cmd_valid, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_stage(); t_order(); t_timed(); t_full(); t_overrun();
      end
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule